// File: doc/BRIEF.md
# Selectable-Interval Time Base Counter

This block divides a slow reference tick (nominally 32.768 kHz, delivered as a one-cycle enable that is already synchronous to the system clock) into periodic events. A cascade of four modulo stages yields quarter-second, second, minute and hour boundaries. A two-bit select picks which boundary is reported. Each reported event can set a sticky interrupt flag, produce a one-cycle wake pulse for stop-mode recovery, or both.

Software or a power controller sets the interval and the two routing enables, and pulses the clear input to acknowledge the interrupt. Dropping the enable returns the whole chain to zero, so the next event comes one full interval after the chain is enabled again.

Top module: `periodic_wake_timer`

## Requirements
- R1: While `en_i` is high, each cycle with `tick_en_i` high advances the chain. A quarter-second event occurs on every PRESCALE_DIV-th tick, which is 8192 by default.
- R2: `sel_i` picks the event: 2'b00 gives the quarter event (PRESCALE_DIV ticks), 2'b01 the second event (times QTR_PER_SEC, default 4), 2'b10 the minute event (times SEC_PER_MIN, default 60) and 2'b11 the hour event (times MIN_PER_HOUR, default 60).
- R3: While `en_i` is low, every stage is held at zero and ticks are ignored. After re-enable, events fall at multiples of the selected period, counted from the first tick after re-enable.
- R4: A change of `sel_i` does not reset the chain. Events fall on ticks whose count since enable is a multiple of the newly selected period.
- R5: An event with `irq_en_i` high sets `irq_flag_o` on the next clock edge. The flag stays set until a cycle with `irq_clr_i` high.
- R6: `irq_clr_i` alone clears the flag at the next edge. If a clear and an enabled event fall in the same cycle, the flag stays set.
- R7: `wake_o` is high for exactly one cycle after each event, and only when `wake_en_i` was high in the event cycle.
- R8: After reset, `irq_flag_o` and `wake_o` are low.
- R9: An event with `irq_en_i` low leaves `irq_flag_o` unchanged. `en_i` does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Synchronized reference tick, one cycle per tick |
| en_i | input | 1 | Chain enable; low holds all stages at zero |
| sel_i | input | 2 | Interval select (00 quarter, 01 second, 10 minute, 11 hour) |
| irq_en_i | input | 1 | Route events to the interrupt flag |
| wake_en_i | input | 1 | Route events to the wake pulse |
| irq_clr_i | input | 1 | Clear pulse for the interrupt flag |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| wake_o | output | 1 | One-cycle stop-mode wake pulse |

## Verification
The stage assertions assume that a tick never reaches a stage while its clear is active. The top-level checks assume `tick_en_i` is a synchronous, single-cycle strobe, so one posedge sees at most one advance. The bench honours this by raising `tick_en_i` for exactly one cycle and holding it low for at least one cycle between ticks. It also changes `sel_i`, `en_i` and the route enables only between ticks. The bench shrinks the stage moduli through parameters, which keeps the hour boundary within a short run. The set-versus-clear collision is hit by placing the clear pulse on the event tick itself.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
   localparam int unsigned NUM_STAGES = 4;

   typedef enum logic [1:0] {
      IVL_QUARTER = 2'b00,
      IVL_SECOND  = 2'b01,
      IVL_MINUTE  = 2'b10,
      IVL_HOUR    = 2'b11
   } interval_e;
endpackage

// File: rtl/pwt_mod_stage.sv
module pwt_mod_stage #(
   parameter int unsigned MODULUS = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic adv_i,
   output logic wrap_o
);
   localparam int unsigned CW = (MODULUS > 1) ? $clog2(MODULUS) : 1;
   localparam logic [CW-1:0] LAST = CW'(MODULUS - 1);

   if (MODULUS < 2) begin : g_bad_modulus
      $error("pwt_mod_stage: MODULUS must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   assign wrap_o = adv_i & ~clr_i & (cnt_q == LAST);

   // R3: a cleared stage is zero on the next edge
   assert_clr_zero_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));

   // R1: an advance below the last value steps by one
   assert_step_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && !clr_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R1: an advance on the last value wraps to zero
   assert_wrap_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/pwt_event_out.sv
module pwt_event_out (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic evt_i,
   input  logic irq_en_i,
   input  logic wake_en_i,
   input  logic irq_clr_i,
   output logic irq_flag_o,
   output logic wake_o
);
   logic flag_q;
   logic wake_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         // set wins over clear
         flag_q <= (evt_i & irq_en_i) | (flag_q & ~irq_clr_i);
         wake_q <= evt_i & wake_en_i;
      end
   end

   assign irq_flag_o = flag_q;
   assign wake_o     = wake_q;

   // R5: the flag holds while no clear is seen
   assert_flag_sticky_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !irq_clr_i) |=> flag_q);

   // R6: a clear and an enabled event together keep the flag set
   assert_set_wins_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i && irq_en_i && irq_clr_i) |=> flag_q);

   // R9: the flag only rises if the interrupt route was enabled
   assert_flag_gated_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q) |-> $past(irq_en_i));

   // R7: a wake pulse needs the wake route enabled
   assert_wake_gated_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_q |-> $past(wake_en_i));
endmodule

// File: rtl/periodic_wake_timer.sv
module periodic_wake_timer #(
   parameter int unsigned PRESCALE_DIV = 8192,
   parameter int unsigned QTR_PER_SEC  = 4,
   parameter int unsigned SEC_PER_MIN  = 60,
   parameter int unsigned MIN_PER_HOUR = 60
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_en_i,
   input  logic       en_i,
   input  logic [1:0] sel_i,
   input  logic       irq_en_i,
   input  logic       wake_en_i,
   input  logic       irq_clr_i,
   output logic       irq_flag_o,
   output logic       wake_o
);
   import pwt_pkg::*;

   localparam int unsigned NS = NUM_STAGES;

   function automatic int unsigned stage_mod(input int unsigned idx);
      case (idx)
         0:       return PRESCALE_DIV;
         1:       return QTR_PER_SEC;
         2:       return SEC_PER_MIN;
         default: return MIN_PER_HOUR;
      endcase
   endfunction

   logic [NS-1:0] adv;
   logic [NS-1:0] wrap;
   logic          evt;
   interval_e     sel;

   assign sel    = interval_e'(sel_i);
   assign adv[0] = tick_en_i & en_i;

   for (genvar g = 0; g < NS; g++) begin : g_stage
      if (g > 0) begin : g_link
         assign adv[g] = wrap[g-1];
      end
      pwt_mod_stage #(
         .MODULUS(stage_mod(g))
      ) u_stage (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .clr_i  (~en_i),
         .adv_i  (adv[g]),
         .wrap_o (wrap[g])
      );
   end

   always_comb begin
      unique case (sel)
         IVL_QUARTER: evt = wrap[0];
         IVL_SECOND:  evt = wrap[1];
         IVL_MINUTE:  evt = wrap[2];
         default:     evt = wrap[3];
      endcase
   end

   pwt_event_out u_out (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt),
      .irq_en_i   (irq_en_i),
      .wake_en_i  (wake_en_i),
      .irq_clr_i  (irq_clr_i),
      .irq_flag_o (irq_flag_o),
      .wake_o     (wake_o)
   );

   // R3: no wake follows a cycle with the chain disabled
   assert_off_no_wake_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !wake_o);

   // R1: no wake follows a cycle without a tick
   assert_tick_needed_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_en_i |=> !wake_o);

   // R2: a coarser boundary only occurs together with every finer one
   assert_nested_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap[3] |-> (wrap[2] && wrap[1] && wrap[0]));
endmodule

// File: tb/periodic_wake_timer_tb.sv
`timescale 1ns/1ps
module periodic_wake_timer_tb;
   localparam int unsigned P = 4;
   localparam int unsigned Q = 4;
   localparam int unsigned S = 3;
   localparam int unsigned M = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b0;
   logic en = 1'b0;
   logic [1:0] sel = 2'b00;
   logic irq_en = 1'b0;
   logic wake_en = 1'b0;
   logic irq_clr = 1'b0;
   logic irq_flag;
   logic wake;

   int n_checks = 0;
   int n_fails = 0;
   int unsigned kcnt = 0;
   logic exp_flag = 1'b0;

   always #2 clk = ~clk;

   periodic_wake_timer #(
      .PRESCALE_DIV(P), .QTR_PER_SEC(Q), .SEC_PER_MIN(S), .MIN_PER_HOUR(M)
   ) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .en_i(en), .sel_i(sel),
      .irq_en_i(irq_en), .wake_en_i(wake_en), .irq_clr_i(irq_clr),
      .irq_flag_o(irq_flag), .wake_o(wake)
   );

   function automatic int unsigned period(input logic [1:0] s);
      case (s)
         2'b00:   return P;
         2'b01:   return P * Q;
         2'b10:   return P * Q * S;
         default: return P * Q * S * M;
      endcase
   endfunction

   task automatic check(input logic act, input logic exp, input string tag, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %b expected %b (tick %0d)", tag, what, act, exp, kcnt);
      end
   endtask

   // one tick, optionally with a clear in the same cycle; checks wake and flag
   task automatic do_tick(input string tag, input logic with_clr);
      logic evt;
      evt = 1'b0;
      if (en) begin
         kcnt++;
         evt = ((kcnt % period(sel)) == 0);
      end
      @(negedge clk);
      tick_en = 1'b1;
      irq_clr = with_clr;
      @(negedge clk);
      tick_en = 1'b0;
      irq_clr = 1'b0;
      exp_flag = (evt & irq_en) | (exp_flag & ~with_clr);
      check(wake, evt & wake_en, tag, "wake after tick");
      check(irq_flag, exp_flag, tag, "irq flag after tick");
      @(negedge clk);
      check(wake, 1'b0, tag, "wake width one cycle");
   endtask

   task automatic run_ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) do_tick(tag, 1'b0);
   endtask

   task automatic t_reset;
      check(irq_flag, 1'b0, "R8", "flag in reset");
      check(wake, 1'b0, "R8", "wake in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(irq_flag, 1'b0, "R8", "flag after reset");
      check(wake, 1'b0, "R8", "wake after reset");
   endtask

   task automatic t_intervals;
      en = 1'b1; wake_en = 1'b1; irq_en = 1'b0; kcnt = 0;
      sel = 2'b00;
      run_ticks(12, "R1");              // quarter events at 4, 8, 12; flag stays low (R9)
      check(irq_flag, 1'b0, "R9", "no flag with irq route off");
      sel = 2'b01;
      run_ticks(8, "R4");               // second event at 16, not 12 + 16
      sel = 2'b10;
      run_ticks(28, "R2");              // minute event at 48
      sel = 2'b11;
      run_ticks(96, "R2");              // hour event at 144
   endtask

   task automatic t_irq;
      sel = 2'b00; irq_en = 1'b1;
      run_ticks(4, "R5");               // event at 148 sets flag
      repeat (5) @(negedge clk);
      check(irq_flag, 1'b1, "R5", "flag sticky over idle cycles");
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      exp_flag = 1'b0;
      check(irq_flag, 1'b0, "R6", "clear alone");
      run_ticks(3, "R6");
      do_tick("R6", 1'b1);              // event at 152 with clear: stays set
      check(irq_flag, 1'b1, "R6", "set wins over clear");
      en = 1'b0;
      @(negedge clk);
      check(irq_flag, 1'b1, "R9", "enable low keeps flag");
      en = 1'b1; kcnt = 0;
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      exp_flag = 1'b0;
      irq_en = 1'b0;
   endtask

   task automatic t_wake_off;
      wake_en = 1'b0;
      run_ticks(4, "R7");               // event at 4, no wake
      wake_en = 1'b1;
      run_ticks(4, "R7");               // event at 8 with wake
   endtask

   task automatic t_disable;
      run_ticks(2, "R3");
      en = 1'b0;
      run_ticks(5, "R3");               // ignored, no events
      en = 1'b1; kcnt = 0;
      run_ticks(4, "R3");               // event exactly at the 4th tick
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset;
      t_intervals;
      t_irq;
      t_wake_off;
      t_disable;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule